// File: doc/BRIEF.md
# Shared-Memory Bit-Serial Add/Subtract Subsystem

This block is a small arithmetic datapath. Several bit-serial processing elements take turns on two word-wide memories. Each element owns a pair of operand shift registers and one result shift register.

A computation works in four steps:
- Operand words are copied in parallel from memory into the element's operand shift registers.
- The operands are streamed one bit per clock, least significant bit first, through a serial adder.
- The sum bits are collected in the result shift register.
- The finished word is stored back to memory in a single parallel access.

Because the memory traffic is only these word-wide transfers, one element can be fetching or storing while another is shifting. Bit-serial work on one operation therefore overlaps memory traffic for another.

Work is issued as a descriptor through a valid/ready handshake. A descriptor holds:
- the operand address in memory 0,
- the operand address in memory 1,
- the destination address and the destination memory,
- the element that runs the operation,
- an add/subtract code.

Each element raises its own one-cycle done pulse when its result has been written. At the same time it shows that word on its result lane.

A simple write port fills the memories before work starts. Each memory allows one access per clock. A per-memory fixed-priority arbiter decides who gets it. The host write port wins first, then elements in ascending index order. A requester that loses keeps its request and waits.

Top module: `bsp_subsys`

## Requirements
- R1: With opcode 0 (add), the stored and reported result is (A + B) modulo 2^DW. A is the word at the source-A address of memory 0 and B is the word at the source-B address of memory 1.
- R2: With opcode 1 (subtract), the result is (A - B) modulo 2^DW, with two's-complement wrap.
- R3: The result is written to the destination address of the memory picked by `op_dst_ram` (0 or 1). A later operation that reads that address sees the new word.
- R4: When nothing else contends for memory, `done` for the element is high in the cycle that follows the DW+2-th rising edge after the accepting edge. The pulse lasts exactly one cycle, and `result` for that element holds the word while it is high.
- R5: `op_ready` is high exactly when the element named by `op_pe` is idle. A descriptor is taken on a rising edge with `op_valid` and `op_ready` both high. An element that is busy does not block descriptors for a different, idle element.
- R6: Each memory performs at most one access per clock. A host write has priority over every element. Among elements, the lowest index is granted first. A stalled element keeps requesting and completes exactly one cycle after the element that beat it.
- R7: The serial carry is re-initialised at the first bit of every word. A wrapped result leaves no carry behind, so an add that wraps does not change the next operation on that element.
- R8: After reset, `done` is all zero, `op_ready` is high for every element, and every memory word reads as zero.
- R9: Two elements run operations at the same time and produce independent, correct results. The second element's operation is accepted while the first is still busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| hw_en | input | 1 | Host write request |
| hw_ram | input | 1 | Memory selected for the host write |
| hw_addr | input | AW | Host write address |
| hw_data | input | DW | Host write data |
| op_valid | input | 1 | Descriptor valid |
| op_ready | output | 1 | The selected element can accept a descriptor |
| op_src_a | input | AW | Operand address in memory 0 |
| op_src_b | input | AW | Operand address in memory 1 |
| op_dst | input | AW | Destination address |
| op_dst_ram | input | 1 | Destination memory (0 or 1) |
| op_pe | input | PIW | Index of the element that runs the operation |
| op_code | input | 1 | 0 add, 1 subtract |
| done | output | NPE | One-cycle completion pulse per element |
| result | output | NPE*DW | Last result of each element, lane i at bits i*DW upward |

## Verification
Two elements can ask for the same memory in the same cycle. The bench forces this as follows:
- It holds a host write on memory 0, which stalls both elements' operand-A fetch.
- While the write is held, it starts one operation on each element.
- It then releases the write, so both elements' memory-0 fetches fall on the same clock.

The arbitration is judged by the completion pulses. The lower-numbered element must finish exactly one cycle before the other, and both results must be correct. A later read of the host's address confirms that the held write went through while the elements were stalled.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

    localparam int NRAM = 2;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_FETCH,
        S_SHIFT,
        S_WB
    } pe_st_e;

    typedef struct packed {
        logic sum;
        logic cout;
    } fa_t;

    function automatic fa_t full_add(input logic a, input logic b, input logic c);
        fa_t r;
        r.sum  = a ^ b ^ c;
        r.cout = (a & b) | (a & c) | (b & c);
        return r;
    endfunction

endpackage

// File: rtl/bsp_ram.sv
module bsp_ram #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    assign rdata = mem[addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end
endmodule

// File: rtl/bsp_arb.sv
module bsp_arb #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        gnt   = '0;
        for (int k = 0; k < N; k++) begin
            if (req[k] && !taken) begin
                gnt[k] = 1'b1;
                taken  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bsp_pe.sv
module bsp_pe
    import bsp_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [AW-1:0]             src_a,
    input  logic [AW-1:0]             src_b,
    input  logic [AW-1:0]             dst,
    input  logic                      dst_ram,
    input  op_e                       code,
    input  logic [NRAM-1:0]           gnt,
    input  logic [NRAM-1:0][DW-1:0]   rdata,
    output logic [NRAM-1:0]           req,
    output logic [NRAM-1:0][AW-1:0]   addr,
    output logic                      wr,
    output logic [DW-1:0]             wdata,
    output logic                      idle,
    output logic                      done,
    output logic [DW-1:0]             result
);
    localparam int CW = (DW > 1) ? $clog2(DW) : 1;

    pe_st_e        st;
    logic [DW-1:0] a_sr, b_sr, res_sr;
    logic [CW-1:0] cnt;
    logic          carry, got_a, got_b;
    logic [AW-1:0] d_a, d_b, d_dst;
    logic          d_ram;
    op_e           d_code;
    logic          sub;
    fa_t           fa;

    assign sub = (d_code == OP_SUB);
    assign fa  = full_add(a_sr[0], b_sr[0] ^ sub, (cnt == '0) ? sub : carry);

    assign req[0]  = (st == S_FETCH && !got_a) || (st == S_WB && !d_ram);
    assign req[1]  = (st == S_FETCH && !got_b) || (st == S_WB && d_ram);
    assign addr[0] = (st == S_WB) ? d_dst : d_a;
    assign addr[1] = (st == S_WB) ? d_dst : d_b;
    assign wr      = (st == S_WB);
    assign wdata   = res_sr;
    assign idle    = (st == S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            a_sr   <= '0;
            b_sr   <= '0;
            res_sr <= '0;
            cnt    <= '0;
            carry  <= 1'b0;
            got_a  <= 1'b0;
            got_b  <= 1'b0;
            d_a    <= '0;
            d_b    <= '0;
            d_dst  <= '0;
            d_ram  <= 1'b0;
            d_code <= OP_ADD;
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                S_IDLE: if (start) begin
                    d_a    <= src_a;
                    d_b    <= src_b;
                    d_dst  <= dst;
                    d_ram  <= dst_ram;
                    d_code <= code;
                    got_a  <= 1'b0;
                    got_b  <= 1'b0;
                    st     <= S_FETCH;
                end
                S_FETCH: begin
                    if (gnt[0] && !got_a) begin
                        a_sr  <= rdata[0];
                        got_a <= 1'b1;
                    end
                    if (gnt[1] && !got_b) begin
                        b_sr  <= rdata[1];
                        got_b <= 1'b1;
                    end
                    if ((got_a || gnt[0]) && (got_b || gnt[1])) begin
                        cnt <= '0;
                        st  <= S_SHIFT;
                    end
                end
                S_SHIFT: begin
                    a_sr   <= a_sr >> 1;
                    b_sr   <= b_sr >> 1;
                    res_sr <= {fa.sum, res_sr[DW-1:1]};
                    carry  <= fa.cout;
                    cnt    <= cnt + 1'b1;
                    if (cnt == CW'(DW - 1)) st <= S_WB;
                end
                S_WB: if (gnt[d_ram]) begin
                    done   <= 1'b1;
                    result <= res_sr;
                    st     <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bsp_subsys.sv
module bsp_subsys
    import bsp_pkg::*;
#(
    parameter int DW  = 16,
    parameter int AW  = 4,
    parameter int NPE = 2,
    parameter int PIW = (NPE > 1) ? $clog2(NPE) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hw_en,
    input  logic              hw_ram,
    input  logic [AW-1:0]     hw_addr,
    input  logic [DW-1:0]     hw_data,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [AW-1:0]     op_src_a,
    input  logic [AW-1:0]     op_src_b,
    input  logic [AW-1:0]     op_dst,
    input  logic              op_dst_ram,
    input  logic [PIW-1:0]    op_pe,
    input  logic              op_code,
    output logic [NPE-1:0]    done,
    output logic [NPE*DW-1:0] result
);
    localparam int NREQ = NPE + 1;

    logic [NRAM-1:0][NREQ-1:0] arb_req, arb_gnt;
    logic [NRAM-1:0][DW-1:0]   ram_rdata;
    logic [NPE-1:0][NRAM-1:0]  pe_req, pe_gnt;
    logic [NPE-1:0][NRAM-1:0][AW-1:0] pe_addr;
    logic [NPE-1:0][DW-1:0]    pe_wdata, pe_res;
    logic [NPE-1:0]            pe_wr, pe_idle, pe_start;

    assign op_ready = (32'(op_pe) < NPE) && pe_idle[op_pe];

    for (genvar r = 0; r < NRAM; r++) begin : g_ram
        logic          m_we;
        logic [AW-1:0] m_addr;
        logic [DW-1:0] m_wd;

        assign arb_req[r][0] = hw_en && (hw_ram == r[0]);
        for (genvar i = 0; i < NPE; i++) begin : g_rq
            assign arb_req[r][i+1] = pe_req[i][r];
            assign pe_gnt[i][r]    = arb_gnt[r][i+1];
        end

        bsp_arb #(.N(NREQ)) i_arb (.req(arb_req[r]), .gnt(arb_gnt[r]));

        always_comb begin
            m_we   = arb_gnt[r][0];
            m_addr = hw_addr;
            m_wd   = hw_data;
            for (int i = 0; i < NPE; i++) begin
                if (arb_gnt[r][i+1]) begin
                    m_we   = pe_wr[i];
                    m_addr = pe_addr[i][r];
                    m_wd   = pe_wdata[i];
                end
            end
        end

        bsp_ram #(.DW(DW), .AW(AW)) i_ram (
            .clk(clk), .rst(rst), .we(m_we), .addr(m_addr),
            .wdata(m_wd), .rdata(ram_rdata[r])
        );
    end

    for (genvar i = 0; i < NPE; i++) begin : g_pe
        assign pe_start[i] = op_valid && op_ready && (32'(op_pe) == i);

        bsp_pe #(.DW(DW), .AW(AW)) i_pe (
            .clk(clk), .rst(rst), .start(pe_start[i]),
            .src_a(op_src_a), .src_b(op_src_b), .dst(op_dst),
            .dst_ram(op_dst_ram), .code(op_e'(op_code)),
            .gnt(pe_gnt[i]), .rdata(ram_rdata),
            .req(pe_req[i]), .addr(pe_addr[i]), .wr(pe_wr[i]),
            .wdata(pe_wdata[i]), .idle(pe_idle[i]),
            .done(done[i]), .result(pe_res[i])
        );

        assign result[i*DW +: DW] = pe_res[i];
    end
endmodule

// File: rtl/bsp_chk.sv
module bsp_chk #(
    parameter int NPE = 2,
    parameter int PIW = 1
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  op_valid,
    input logic                  op_ready,
    input logic [PIW-1:0]        op_pe,
    input logic [NPE-1:0]        done,
    input logic [1:0][NPE:0]     req,
    input logic [1:0][NPE:0]     gnt
);
    for (genvar r = 0; r < 2; r++) begin : g_r
        assert_one_access_R6: assert property (@(posedge clk) disable iff (rst)
            $onehot0(gnt[r]));
        assert_grant_needs_req_R6: assert property (@(posedge clk) disable iff (rst)
            (gnt[r] & ~req[r]) == '0);
        assert_no_idle_memory_R6: assert property (@(posedge clk) disable iff (rst)
            (req[r] != '0) |-> (gnt[r] != '0));
        assert_host_first_R6: assert property (@(posedge clk) disable iff (rst)
            req[r][0] |-> gnt[r][0]);
        for (genvar i = 1; i <= NPE; i++) begin : g_i
            assert_low_index_first_R6: assert property (@(posedge clk) disable iff (rst)
                (req[r][i] && (req[r][i-1:0] == '0)) |-> gnt[r][i]);
            assert_stall_holds_R6: assert property (@(posedge clk) disable iff (rst)
                (req[r][i] && !gnt[r][i]) |=> req[r][i]);
        end
    end

    for (genvar i = 0; i < NPE; i++) begin : g_d
        assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
            done[i] |=> !done[i]);
    end

    assert_busy_after_accept_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_ready) |=> (op_pe != $past(op_pe) || !op_ready));
endmodule

bind bsp_subsys bsp_chk #(.NPE(NPE), .PIW(PIW)) i_chk (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_pe(op_pe), .done(done), .req(arb_req), .gnt(arb_gnt)
);

// File: tb/test_bsp_subsys.sv
module test_bsp_subsys;
    localparam int DW = 16;
    localparam int AW = 4;
    localparam int NPE = 2;
    localparam int PIW = 1;

    logic clk = 0, rst = 1;
    logic hw_en = 0, hw_ram = 0;
    logic [AW-1:0] hw_addr = '0;
    logic [DW-1:0] hw_data = '0;
    logic op_valid = 0, op_ready, op_dst_ram = 0, op_code = 0;
    logic [AW-1:0] op_src_a = '0, op_src_b = '0, op_dst = '0;
    logic [PIW-1:0] op_pe = '0;
    logic [NPE-1:0] done;
    logic [NPE*DW-1:0] result;

    int total = 0, bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    bsp_subsys #(.DW(DW), .AW(AW), .NPE(NPE), .PIW(PIW)) i_bsp_subsys (
        .clk(clk), .rst(rst), .hw_en(hw_en), .hw_ram(hw_ram), .hw_addr(hw_addr),
        .hw_data(hw_data), .op_valid(op_valid), .op_ready(op_ready),
        .op_src_a(op_src_a), .op_src_b(op_src_b), .op_dst(op_dst),
        .op_dst_ram(op_dst_ram), .op_pe(op_pe), .op_code(op_code),
        .done(done), .result(result)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic ram, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        hw_en = 1; hw_ram = ram; hw_addr = a; hw_data = d;
        @(negedge clk);
        hw_en = 0;
    endtask

    task automatic issue(input int pe, input logic [AW-1:0] a, input logic [AW-1:0] b,
                         input logic [AW-1:0] d, input logic dram, input logic code);
        @(negedge clk);
        op_pe = PIW'(pe); op_src_a = a; op_src_b = b; op_dst = d;
        op_dst_ram = dram; op_code = code; op_valid = 1;
        #1;
        while (!op_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        op_valid = 0;
    endtask

    task automatic wait_one(input int pe, output logic [DW-1:0] w, output int n);
        n = 0; w = '0;
        for (int k = 0; k < 200; k++) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (done[pe]) begin w = result[pe*DW +: DW]; return; end
        end
        n = -1;
    endtask

    task automatic wait_both(output logic [DW-1:0] w0, output logic [DW-1:0] w1,
                             output int t0, output int t1);
        t0 = -1; t1 = -1; w0 = '0; w1 = '0;
        for (int n = 1; n <= 200; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (done[0] && t0 < 0) begin t0 = n; w0 = result[DW-1:0]; end
            if (done[1] && t1 < 0) begin t1 = n; w1 = result[2*DW-1:DW]; end
            if (t0 >= 0 && t1 >= 0) return;
        end
    endtask

    task automatic t_reset;
        logic [DW-1:0] w; int n;
        @(negedge clk);
        check("R8 done after reset", 32'(done), 0);
        op_pe = 0; #1; check("R8 ready pe0", 32'(op_ready), 1);
        op_pe = 1; #1; check("R8 ready pe1", 32'(op_ready), 1);
        issue(0, 7, 7, 8, 0, 0);
        wait_one(0, w, n);
        check("R8 cleared memory", 32'(w), 0);
    endtask

    task automatic t_add;
        logic [DW-1:0] w; int n;
        host_wr(0, 1, 16'h1234);
        host_wr(1, 1, 16'h0F0F);
        issue(0, 1, 1, 2, 1, 0);
        wait_one(0, w, n);
        check("R1 add 1234+0F0F", 32'(w), 32'h2143);
        check("R4 latency", 32'(n), DW + 2);
        @(negedge clk);
        check("R4 done one cycle", 32'(done[0]), 0);
        host_wr(0, 3, 16'hFFFF);
        host_wr(1, 3, 16'h0002);
        issue(1, 3, 3, 6, 0, 0);
        wait_one(1, w, n);
        check("R1 add wraps", 32'(w), 32'h0001);
    endtask

    task automatic t_carry;
        logic [DW-1:0] w; int n;
        issue(1, 4, 4, 7, 0, 0);
        wait_one(1, w, n);
        check("R7 no carry after wrap", 32'(w), 0);
    endtask

    task automatic t_sub;
        logic [DW-1:0] w; int n;
        host_wr(0, 5, 16'h0003);
        host_wr(1, 5, 16'h0005);
        issue(1, 5, 5, 9, 1, 1);
        wait_one(1, w, n);
        check("R2 sub 3-5", 32'(w), 32'hFFFE);
        host_wr(0, 11, 16'h8000);
        host_wr(1, 11, 16'h0001);
        issue(0, 11, 11, 12, 0, 1);
        wait_one(0, w, n);
        check("R2 sub 8000-1", 32'(w), 32'h7FFF);
    endtask

    task automatic t_writeback;
        logic [DW-1:0] w; int n;
        issue(0, 1, 2, 5, 0, 0);
        wait_one(0, w, n);
        check("R3 reads result in memory 1", 32'(w), 32'h3377);
        issue(1, 5, 1, 13, 0, 1);
        wait_one(1, w, n);
        check("R3 reads result in memory 0", 32'(w), 32'h2468);
    endtask

    task automatic t_ready;
        logic [DW-1:0] w; int n;
        issue(0, 1, 1, 14, 1, 0);
        op_pe = 0; #1; check("R5 busy pe not ready", 32'(op_ready), 0);
        op_pe = 1; #1; check("R5 idle pe ready", 32'(op_ready), 1);
        wait_one(0, w, n);
        op_pe = 0; #1; check("R5 ready after done", 32'(op_ready), 1);
    endtask

    task automatic t_concurrent;
        logic [DW-1:0] w0, w1; int t0, t1;
        host_wr(0, 6, 16'h1111);
        host_wr(1, 6, 16'h2222);
        host_wr(0, 7, 16'h0010);
        host_wr(1, 7, 16'h0020);
        issue(0, 6, 6, 0, 0, 0);
        issue(1, 7, 7, 0, 1, 1);
        wait_both(w0, w1, t0, t1);
        check("R9 pe0 result", 32'(w0), 32'h3333);
        check("R9 pe1 result", 32'(w1), 32'hFFF0);
        check("R9 overlap gap", 32'(t1 - t0), 2);
    endtask

    task automatic t_contention;
        logic [DW-1:0] w0, w1, w; int t0, t1, n;
        host_wr(0, 9, 16'h0100);
        host_wr(1, 9, 16'h0023);
        host_wr(0, 10, 16'h0500);
        host_wr(1, 10, 16'h0004);
        host_wr(1, 15, 16'h0000);
        @(negedge clk);
        hw_en = 1; hw_ram = 0; hw_addr = 15; hw_data = 16'hABCD;
        issue(0, 9, 9, 3, 1, 0);
        issue(1, 10, 10, 4, 1, 1);
        repeat (3) @(negedge clk);
        hw_en = 0;
        wait_both(w0, w1, t0, t1);
        check("R6 pe0 result", 32'(w0), 32'h0123);
        check("R6 pe1 result", 32'(w1), 32'h04FC);
        check("R6 lower index one cycle first", 32'(t1 - t0), 1);
        issue(0, 15, 15, 1, 1, 0);
        wait_one(0, w, n);
        check("R6 host write took effect", 32'(w), 32'hABCD);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        t_reset;
        t_add;
        t_carry;
        t_sub;
        t_writeback;
        t_ready;
        t_concurrent;
        t_contention;
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule